// File: doc/BRIEF.md
# FSK Carrier Detector with Dropout Hold

This block decides whether in-band FSK energy is present on the line and drives an active-low carrier-detect output. A front end outside the block compares the band-pass filter output against a level threshold and presents the result as a single activity flag each clock. Time is divided into fixed observation windows, nominally 1 ms each. A window counts as active if the flag was high in any of its cycles. The carrier is declared once enough windows in a sliding history are active.

Once the carrier is declared, the output stays low through short gaps in activity. It is released only after a fixed quiet period, nominally eight windows long, with no activity at all. Dropping the FSK enable or raising power-down forces the output inactive and wipes all qualification state, so speech or alert tones heard while disabled cannot count toward a later detection. The output also serves downstream as the gate for the serial data interface.

Top module: `fsk_carrier_detect`

## Requirements
- R1: After synchronous reset `cd_n_o` is high (inactive) and no window of history is counted.
- R2: Windows are `WIN_CYC` cycles long and start on the first enabled cycle. A window is active when `act_i` is high in at least one of its cycles.
- R3: With the detector idle, `cd_n_o` goes low on the clock edge that follows the edge closing a window, when at least `QUAL_N` of the last `HIST_M` closed windows were active.
- R4: When `act_i` is held high continuously from a fresh enable, `cd_n_o` falls no later than `(QUAL_N+1)*WIN_CYC+1` cycles after the enable.
- R5: While `cd_n_o` is low, any run of fewer than `HOLD_WIN*WIN_CYC` consecutive cycles with `act_i` low leaves it low. Each active cycle restarts the quiet count.
- R6: `cd_n_o` returns high on the edge that ends the `HOLD_WIN*WIN_CYC`-th consecutive quiet cycle. That edge also empties the window history, so a new full qualification is needed.
- R7: While `fsk_en_i` is low, `cd_n_o` is high from the next edge on, `act_i` is ignored, and the history and window phase are cleared. Re-enabling starts a fresh qualification.
- R8: While `pwdn_i` is high, the block behaves as in R7 whatever the level of `fsk_en_i`.
- R9: Active windows do not need to be consecutive. Any `QUAL_N` active windows among the last `HIST_M` qualify, and `QUAL_N-1` do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsk_en_i | input | 1 | FSK enable; low disables detection |
| pwdn_i | input | 1 | Power-down; high disables detection |
| act_i | input | 1 | Band-pass output above level threshold this cycle |
| cd_n_o | output | 1 | Carrier detect, active low |

## Verification
The bench measures the exact assert latency from a fresh enable. A design that qualifies one window early or late, or that fails to restart the window phase on enable, shows up as a cycle-count mismatch.

It probes the quiet-period boundary on both sides: one cycle short must hold the carrier, and the exact count must release it. An off-by-one timer, or a timer that does not restart on activity, would drop the carrier early or hold it too long.

Scattered-window patterns with exactly `QUAL_N` and `QUAL_N-1` active windows expose a design that demands consecutive windows or miscounts the history. Activity applied while disabled, followed by a re-enable, exposes history that survives a disable. Long randomized stretches are then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/fsk_cd_pkg.sv
package fsk_cd_pkg;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_LOCK = 1'b1
    } cd_state_e;

    typedef struct packed {
        logic done;
        logic act;
    } win_evt_t;

endpackage

// File: rtl/fsk_cd_window.sv
module fsk_cd_window
    import fsk_cd_pkg::*;
#(
    parameter int WIN_CYC = 50000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     act_i,
    output win_evt_t evt_o
);
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

    logic [WW-1:0] wcnt;
    logic          seen;
    logic          at_end;

    assign at_end     = (wcnt == LAST);
    assign evt_o.done = at_end && !clr;
    assign evt_o.act  = seen | act_i;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wcnt <= '0;
            seen <= 1'b0;
        end else if (at_end) begin
            wcnt <= '0;
            seen <= 1'b0;
        end else begin
            wcnt <= wcnt + 1'b1;
            seen <= seen | act_i;
        end
    end

    p_wcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        wcnt <= LAST);

    p_clr_phase_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (wcnt == '0 && !seen));

endmodule

// File: rtl/fsk_cd_history.sv
module fsk_cd_history
    import fsk_cd_pkg::*;
#(
    parameter int HIST_M = 8,
    parameter int QUAL_N = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  win_evt_t evt_i,
    output logic     qualified_o
);
    localparam int CW = $clog2(HIST_M + 1);

    logic [HIST_M-1:0] hist;
    logic [CW-1:0]     ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < HIST_M; i++) begin
            ones = ones + CW'(hist[i]);
        end
    end

    assign qualified_o = (ones >= CW'(QUAL_N));

    generate
        if (HIST_M > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst || clr)      hist <= '0;
                else if (evt_i.done) hist <= {hist[HIST_M-2:0], evt_i.act};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clr)      hist <= '0;
                else if (evt_i.done) hist <= evt_i.act;
            end
        end
    endgenerate

    p_clr_empties_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist == '0));

    p_hist_static_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !evt_i.done) |=> $stable(hist));

endmodule

// File: rtl/fsk_cd_hold.sv
module fsk_cd_hold #(
    parameter int HOLD_CYC = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic act_i,
    output logic expire_o
);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hcnt;

    assign expire_o = run && !act_i && (hcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || act_i) hcnt <= '0;
        else if (hcnt != LAST)    hcnt <= hcnt + 1'b1;
    end

    p_hold_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (run && act_i) |=> (hcnt == '0));

    p_hold_range_r6: assert property (@(posedge clk) disable iff (rst)
        hcnt <= LAST);

endmodule

// File: rtl/fsk_carrier_detect.sv
module fsk_carrier_detect
    import fsk_cd_pkg::*;
#(
    parameter int WIN_CYC  = 50000,
    parameter int HIST_M   = 8,
    parameter int QUAL_N   = 8,
    parameter int HOLD_WIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fsk_en_i,
    input  logic pwdn_i,
    input  logic act_i,
    output logic cd_n_o
);
    localparam int HOLD_CYC = HOLD_WIN * WIN_CYC;

    cd_state_e state;
    logic      en;
    logic      clr_q;
    logic      qualified;
    logic      expire;
    win_evt_t  evt;

    assign en     = fsk_en_i && !pwdn_i;
    assign clr_q  = !en || expire;
    assign cd_n_o = (state != CD_LOCK);

    fsk_cd_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_q),
        .act_i(act_i && en),
        .evt_o(evt)
    );

    fsk_cd_history #(.HIST_M(HIST_M), .QUAL_N(QUAL_N)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_q),
        .evt_i      (evt),
        .qualified_o(qualified)
    );

    fsk_cd_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .run     (en && state == CD_LOCK),
        .act_i   (act_i),
        .expire_o(expire)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= CD_IDLE;
        end else begin
            case (state)
                CD_IDLE: if (qualified) state <= CD_LOCK;
                CD_LOCK: if (expire)    state <= CD_IDLE;
                default:                state <= CD_IDLE;
            endcase
        end
    end

    p_off_forces_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> cd_n_o);

    p_fall_needs_qual_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cd_n_o) |-> $past(qualified));

    p_rise_after_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cd_n_o) && $past(en)) |-> $past(!act_i));

    p_act_keeps_lock_r5: assert property (@(posedge clk) disable iff (rst)
        (!cd_n_o && en && act_i) |=> (!cd_n_o || !$past(en)));

endmodule

// File: tb/fsk_carrier_detect_tb.sv
module fsk_carrier_detect_tb;
    localparam int W    = 20;
    localparam int M    = 8;
    localparam int N    = 6;
    localparam int HW   = 8;
    localparam int HOLD = HW * W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsk_en = 1'b0;
    logic pwdn = 1'b0;
    logic act = 1'b0;
    logic cd_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fsk_carrier_detect #(.WIN_CYC(W), .HIST_M(M), .QUAL_N(N), .HOLD_WIN(HW)) u_dut (
        .clk(clk), .rst(rst), .fsk_en_i(fsk_en), .pwdn_i(pwdn),
        .act_i(act), .cd_n_o(cd_n)
    );

    // bench reference model built from the requirements
    int       m_wpos;
    bit       m_seen;
    bit [M-1:0] m_hist;
    bit       m_lock;
    int       m_quiet;

    function automatic int ones_of(bit [M-1:0] h);
        int c = 0;
        for (int i = 0; i < M; i++) c += h[i];
        return c;
    endfunction

    always @(posedge clk) begin
        bit         en_b;
        bit         closes;
        bit [M-1:0] nh;
        en_b = fsk_en && !pwdn;
        if (rst || !en_b) begin
            m_wpos = 0; m_seen = 0; m_hist = '0; m_lock = 0; m_quiet = 0;
        end else begin
            closes = (m_wpos == W - 1);
            nh = closes ? {m_hist[M-2:0], bit'(m_seen | act)} : m_hist;
            if (!m_lock) begin
                if (ones_of(m_hist) >= N) m_lock = 1;
                m_quiet = 0;
                m_hist = nh;
                m_seen = closes ? 1'b0 : (m_seen | act);
                m_wpos = closes ? 0 : m_wpos + 1;
            end else if (!act && m_quiet == HOLD - 1) begin
                m_lock = 0; m_quiet = 0; m_hist = '0; m_seen = 0; m_wpos = 0;
            end else begin
                m_quiet = act ? 0 : m_quiet + 1;
                m_hist = nh;
                m_seen = closes ? 1'b0 : (m_seen | act);
                m_wpos = closes ? 0 : m_wpos + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, int actual, int expected);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) chk(cd_n === !m_lock, "R3 model compare", int'(cd_n), int'(!m_lock));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_fall(string req);
        int cnt = 0;
        while (cd_n && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == N * W + 1, req, cnt, N * W + 1);
        chk(cnt <= (N + 1) * W + 1, "R4 latency bound", cnt, (N + 1) * W + 1);
    endtask

    task automatic report;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        tick(4);
        chk(cd_n === 1'b1, "R1 reset state", int'(cd_n), 1);
        rst = 1'b0;
        tick(2);
        chk(cd_n === 1'b1, "R1 idle after reset", int'(cd_n), 1);

        // continuous activity from a fresh enable
        fsk_en = 1'b1; act = 1'b1;
        measure_fall("R3 assert latency");

        // dropout one cycle short of the hold period
        act = 1'b0;
        tick(HOLD - 1);
        act = 1'b1;
        tick(1);
        chk(cd_n === 1'b0, "R5 dropout held", int'(cd_n), 0);
        tick(5);

        // full quiet period releases exactly
        act = 1'b0;
        tick(HOLD - 1);
        chk(cd_n === 1'b0, "R6 not released early", int'(cd_n), 0);
        tick(1);
        chk(cd_n === 1'b1, "R6 released at hold end", int'(cd_n), 1);
        act = 1'b1;
        tick(2 * W);
        chk(cd_n === 1'b1, "R6 requalification needed", int'(cd_n), 1);
        tick(N * W);
        chk(cd_n === 1'b0, "R6 requalified", int'(cd_n), 0);

        // enable low
        fsk_en = 1'b0;
        tick(1);
        chk(cd_n === 1'b1, "R7 disable drops output", int'(cd_n), 1);
        tick(10 * W);
        chk(cd_n === 1'b1, "R7 activity ignored while disabled", int'(cd_n), 1);
        fsk_en = 1'b1;
        measure_fall("R7 fresh qualification");

        // power-down dominates enable
        pwdn = 1'b1;
        tick(1);
        chk(cd_n === 1'b1, "R8 power-down drops output", int'(cd_n), 1);
        tick(5 * W);
        chk(cd_n === 1'b1, "R8 held off in power-down", int'(cd_n), 1);
        pwdn = 1'b0;
        measure_fall("R8 fresh after power-down");

        // scattered windows: N-1 active must not qualify
        fsk_en = 1'b0; act = 1'b0;
        tick(1);
        fsk_en = 1'b1;
        for (int w = 0; w < M; w++) begin
            act = (8'b1011_0101 >> w) & 1'b1;
            tick(1);
            act = 1'b0;
            tick(W - 1);
        end
        tick(2);
        chk(cd_n === 1'b1, "R9 N-1 windows not enough", int'(cd_n), 1);

        // scattered windows: exactly N active qualifies
        fsk_en = 1'b0;
        tick(1);
        fsk_en = 1'b1;
        for (int w = 0; w < M; w++) begin
            act = (8'b1101_1011 >> w) & 1'b1;
            tick(1);
            act = 1'b0;
            tick(W - 1);
        end
        chk(cd_n === 1'b1, "R9 not before last window", int'(cd_n), 1);
        tick(1);
        chk(cd_n === 1'b0, "R9 N scattered windows qualify", int'(cd_n), 0);
        tick(HOLD + 2);
        chk(cd_n === 1'b1, "R6 release after scattered", int'(cd_n), 1);

        // constrained random stretches checked by the model
        for (int seg = 0; seg < 150; seg++) begin
            int len;
            int dens;
            int sel;
            len = 1 + ($urandom % 300);
            sel = $urandom % 16;
            dens = (sel < 4) ? 0 : (sel < 8) ? 3 : (sel < 12) ? 50 : 100;
            fsk_en = ($urandom % 10) != 0;
            pwdn   = ($urandom % 14) == 0;
            for (int c = 0; c < len; c++) begin
                act = ($urandom % 100) < dens;
                tick(1);
            end
        end
        act = 1'b0; fsk_en = 1'b1; pwdn = 1'b0;
        tick(HOLD + 2);
        chk(cd_n === 1'b1, "R6 final release", int'(cd_n), 1);
        report();
    end
endmodule